// File: doc/BRIEF.md
# Cache Attribute Combiner and Remapper

This block works out the effective memory type of one guest page and turns it into the attribute bits a host page-table entry needs. It takes the three attribute flags of a guest page-table entry and uses them to pick one byte of the guest attribute table register. It combines that table type with a range-based memory type using the fixed combination rules. It then looks for a table type that, combined with the host range type, gives the same effective type. Finally it finds where that type sits in the host attribute table and emits that slot number as host page flags.

A page-walk engine fires `req_valid` for one cycle with the entry flags, the guest table value and the range types. The block registers its results and raises `rsp_valid` on the next cycle. The host attribute table is held in a register inside the block and is loaded with `hpat_load`. A bypass input can replace the range resolver's type for the guest combination step.

Control is a two-state machine. `S_IDLE` means no result was produced in the last cycle. `S_RESP` means a fresh result is on the outputs. There are four transitions:
- IDLE_TO_RESP on a request.
- RESP_TO_RESP on a back-to-back request.
- RESP_TO_IDLE when no request arrives.
- IDLE_HOLD otherwise.

Top module: `cattr_remapper`

## Requirements
- R1: After reset, `rsp_valid`, `eff_type`, `host_flags` and `conflict` are 0, and the host table holds 64'h0007040600070406. Byte n of that value is slot n, so slot 0 = WB, slot 1 = WT, slot 2 = UC-, slot 3 = UC, and slots 4 to 7 repeat the same four types.
- R2: The table index is `{pte_pat, pte_pcd, pte_pwt}`, with the PWT flag as bit 0. The guest table type used is `guest_pat[8*idx+7 : 8*idx]`.
- R3: Type codes are UC=0, WC=1, WT=4, WP=5, WB=6 and UC-=7; codes 2 and 3 are reserved. With a range type of UC, the result is UC for every valid table type except WC, which gives WC. With a range type of WC, table UC gives UC, WC gives WC, WT and WP give UC, and WB and UC- give WC.
- R4: With a range type of WT, table types UC, WC, WT and WP pass through, WB gives WT and UC- gives UC. With a range type of WP, the same four pass through, WB gives WP and UC- gives WC. With a range type of WB, the table type passes through, except that UC- gives UC. A range type outside {0,1,4,5,6}, or a table type outside {0,1,4,5,6,7}, gives the reserved code 2.
- R5: While `bypass_valid` is 1, `bypass_mtrr` replaces `range_mtrr` in the guest combination. While it is 0, `bypass_mtrr` has no effect.
- R6: The remap type is the highest-numbered code in {0,1,4,5,6,7} whose combination (rules R3 and R4) with `host_mtrr` equals the effective type. If no such code exists, the remap type is UC and `conflict` is 1; otherwise `conflict` is 0.
- R7: `host_flags` is the lowest host slot whose byte equals the remap type. If no slot matches, it is the lowest slot holding UC, and if there is none of those either, it is 0. Bit 0 of `host_flags` is PWT, bit 1 is PCD and bit 2 is PAT.
- R8: Results and `rsp_valid`=1 appear one cycle after `req_valid`. `rsp_valid` is 0 in a cycle that follows no request, and the result outputs then hold their values.
- R9: `hpat_load` writes `hpat_in` into the host table on that clock edge. A request in the same cycle still sees the old table; later requests see the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpat_load | input | 1 | Load strobe for the host attribute table |
| hpat_in | input | 64 | New host attribute table value |
| req_valid | input | 1 | Request pulse |
| pte_pwt | input | 1 | Entry flag, index bit 0 |
| pte_pcd | input | 1 | Entry flag, index bit 1 |
| pte_pat | input | 1 | Entry flag, index bit 2 |
| guest_pat | input | 64 | Guest attribute table register |
| range_mtrr | input | 8 | Guest range type from the range resolver |
| bypass_valid | input | 1 | Selects the bypass range type |
| bypass_mtrr | input | 8 | Bypass guest range type |
| host_mtrr | input | 8 | Host range type |
| rsp_valid | output | 1 | Result valid |
| eff_type | output | 8 | Guest effective memory type |
| host_flags | output | 3 | Host page flags {PAT, PCD, PWT} |
| conflict | output | 1 | No table type reproduces the effective type |

## Verification
Some properties are checked on every cycle:
- the response timing, and the holding of results between requests;
- the load and hold behaviour of the host table;
- that the effective type is never 3 or UC-;
- that a UC range type forces UC except for table WC;
- that a non-conflicting remap type really recombines to the effective type;
- that the chosen slot really holds the remap type.

Other behaviours need the bench's scenarios to show them:
- that the highest matching code wins;
- the lowest-slot priority among duplicate slots;
- the UC-slot fallback and the slot-0 fallback;
- the old-table view of a request issued during a load;
- the bypass selection.

// File: rtl/cattr_pkg.sv
package cattr_pkg;

    localparam int TW = 8;

    localparam logic [TW-1:0] MT_UC  = 8'd0;
    localparam logic [TW-1:0] MT_WC  = 8'd1;
    localparam logic [TW-1:0] MT_RSV = 8'd2;
    localparam logic [TW-1:0] MT_WT  = 8'd4;
    localparam logic [TW-1:0] MT_WP  = 8'd5;
    localparam logic [TW-1:0] MT_WB  = 8'd6;
    localparam logic [TW-1:0] MT_UCM = 8'd7;

    // Legal codes for a range type.
    function automatic logic range_ok(input logic [TW-1:0] t);
        return (t == MT_UC) || (t == MT_WC) || (t == MT_WT) ||
               (t == MT_WP) || (t == MT_WB);
    endfunction

    // Legal codes for a table type (range codes plus UC-).
    function automatic logic table_ok(input logic [TW-1:0] t);
        return range_ok(t) || (t == MT_UCM);
    endfunction

    // Combination of a range type with a table type.
    function automatic logic [TW-1:0] mt_combine(input logic [TW-1:0] rng,
                                                 input logic [TW-1:0] tbl);
        logic [TW-1:0] r;
        r = MT_RSV;
        if (range_ok(rng) && table_ok(tbl)) begin
            unique case (rng)
                MT_UC: begin
                    r = (tbl == MT_WC) ? MT_WC : MT_UC;
                end
                MT_WC: begin
                    if (tbl == MT_WC || tbl == MT_WB || tbl == MT_UCM)
                        r = MT_WC;
                    else
                        r = MT_UC;
                end
                MT_WT: begin
                    if (tbl == MT_WB)
                        r = MT_WT;
                    else if (tbl == MT_UCM)
                        r = MT_UC;
                    else
                        r = tbl;
                end
                MT_WP: begin
                    if (tbl == MT_WB)
                        r = MT_WP;
                    else if (tbl == MT_UCM)
                        r = MT_WC;
                    else
                        r = tbl;
                end
                default: begin
                    r = (tbl == MT_UCM) ? MT_UC : tbl;
                end
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/cattr_pat_pick.sv
module cattr_pat_pick
    import cattr_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int IDX_W = $clog2(NUM_SLOTS),
    localparam int PAT_W = NUM_SLOTS * TW
) (
    input  logic [PAT_W-1:0] pat_reg,
    input  logic [IDX_W-1:0] idx,
    output logic [TW-1:0]    tbl_type
);

    logic [TW-1:0] bytes [NUM_SLOTS];

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_byte
        assign bytes[k] = pat_reg[k*TW +: TW];
    end

    assign tbl_type = bytes[idx];

endmodule

// File: rtl/cattr_combine.sv
module cattr_combine
    import cattr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] rng_type,
    input  logic [TW-1:0] tbl_type,
    output logic [TW-1:0] eff
);

    assign eff = mt_combine(rng_type, tbl_type);

    // R4
    // The effective type is never reserved code 3, and never UC-.
    eff_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff != 8'd3) && (eff != MT_UCM));

    // R3
    // A UC range type forces UC unless the table type is WC.
    uc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rng_type == MT_UC && table_ok(tbl_type) && tbl_type != MT_WC)
            |-> (eff == MT_UC));

endmodule

// File: rtl/cattr_host_map.sv
module cattr_host_map
    import cattr_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int IDX_W = $clog2(NUM_SLOTS),
    localparam int PAT_W = NUM_SLOTS * TW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    host_mtrr,
    input  logic [TW-1:0]    eff,
    input  logic [PAT_W-1:0] hpat,
    output logic [IDX_W-1:0] slot,
    output logic             conflict
);

    logic [TW-1:0]        remap_type;
    logic                 found;
    logic [NUM_SLOTS-1:0] hit;
    logic [NUM_SLOTS-1:0] uc_at;
    logic                 hit_any;

    // Reverse search: the highest legal table code that reproduces eff.
    always_comb begin
        found      = 1'b0;
        remap_type = MT_UC;
        for (int j = 0; j < 8; j++) begin
            if (table_ok(TW'(j)) && (mt_combine(host_mtrr, TW'(j)) == eff)) begin
                found      = 1'b1;
                remap_type = TW'(j);
            end
        end
    end

    assign conflict = !found;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign hit[k]   = (hpat[k*TW +: TW] == remap_type);
        assign uc_at[k] = (hpat[k*TW +: TW] == MT_UC);
    end

    // Lowest matching slot wins; fall back to the lowest UC slot, then slot 0.
    always_comb begin
        slot    = '0;
        hit_any = 1'b0;
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            if (uc_at[k]) slot = IDX_W'(k);
        end
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            if (hit[k]) begin
                slot    = IDX_W'(k);
                hit_any = 1'b1;
            end
        end
    end

    // R6
    conflict_uc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (remap_type == MT_UC));

    // R6
    remap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conflict |-> (mt_combine(host_mtrr, remap_type) == eff));

    // R7
    slot_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> (hpat[slot*TW +: TW] == remap_type));

endmodule

// File: rtl/cattr_remapper.sv
module cattr_remapper
    import cattr_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter logic [NUM_SLOTS*8-1:0] HPAT_RESET = 64'h0007040600070406,
    localparam int IDX_W = $clog2(NUM_SLOTS),
    localparam int PAT_W = NUM_SLOTS * TW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hpat_load,
    input  logic [PAT_W-1:0] hpat_in,
    input  logic             req_valid,
    input  logic             pte_pwt,
    input  logic             pte_pcd,
    input  logic             pte_pat,
    input  logic [PAT_W-1:0] guest_pat,
    input  logic [TW-1:0]    range_mtrr,
    input  logic             bypass_valid,
    input  logic [TW-1:0]    bypass_mtrr,
    input  logic [TW-1:0]    host_mtrr,
    output logic             rsp_valid,
    output logic [TW-1:0]    eff_type,
    output logic [IDX_W-1:0] host_flags,
    output logic             conflict
);

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } state_e;

    state_e state_q, state_d;

    logic [PAT_W-1:0] hpat_q;
    logic [IDX_W-1:0] tbl_idx;
    logic [TW-1:0]    tbl_type;
    logic [TW-1:0]    rng_sel;
    logic [TW-1:0]    eff_c;
    logic [IDX_W-1:0] slot_c;
    logic             conflict_c;

    // Host attribute table register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hpat_q <= HPAT_RESET;
        else if (hpat_load)
            hpat_q <= hpat_in;
    end

    assign tbl_idx = IDX_W'({pte_pat, pte_pcd, pte_pwt});
    assign rng_sel = bypass_valid ? bypass_mtrr : range_mtrr;

    cattr_pat_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .pat_reg  (guest_pat),
        .idx      (tbl_idx),
        .tbl_type (tbl_type)
    );

    cattr_combine u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rng_type (rng_sel),
        .tbl_type (tbl_type),
        .eff      (eff_c)
    );

    cattr_host_map #(.NUM_SLOTS(NUM_SLOTS)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_mtrr (host_mtrr),
        .eff       (eff_c),
        .hpat      (hpat_q),
        .slot      (slot_c),
        .conflict  (conflict_c)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = req_valid ? S_RESP : S_IDLE;
            S_RESP: state_d = req_valid ? S_RESP : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_type   <= '0;
            host_flags <= '0;
            conflict   <= 1'b0;
        end else if (req_valid) begin
            eff_type   <= eff_c;
            host_flags <= slot_c;
            conflict   <= conflict_c;
        end
    end

    assign rsp_valid = (state_q == S_RESP);

    // R8
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(eff_type) && $stable(host_flags) && $stable(conflict)));

    // R9
    hpat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hpat_load |=> $stable(hpat_q));

    // R9
    hpat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hpat_load |=> (hpat_q == $past(hpat_in)));

endmodule

// File: tb/cattr_remapper_tb.sv
module cattr_remapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hpat_load = 1'b0;
    logic [63:0] hpat_in = '0;
    logic        req_valid = 1'b0;
    logic        pte_pwt = 1'b0, pte_pcd = 1'b0, pte_pat = 1'b0;
    logic [63:0] guest_pat = '0;
    logic [7:0]  range_mtrr = '0;
    logic        bypass_valid = 1'b0;
    logic [7:0]  bypass_mtrr = '0;
    logic [7:0]  host_mtrr = '0;
    logic        rsp_valid;
    logic [7:0]  eff_type;
    logic [2:0]  host_flags;
    logic        conflict;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [63:0] model_hpat = 64'h0007040600070406;

    always #10 clk = ~clk;

    cattr_remapper u_dut (
        .clk(clk), .rst_n(rst_n), .hpat_load(hpat_load), .hpat_in(hpat_in),
        .req_valid(req_valid), .pte_pwt(pte_pwt), .pte_pcd(pte_pcd), .pte_pat(pte_pat),
        .guest_pat(guest_pat), .range_mtrr(range_mtrr), .bypass_valid(bypass_valid),
        .bypass_mtrr(bypass_mtrr), .host_mtrr(host_mtrr), .rsp_valid(rsp_valid),
        .eff_type(eff_type), .host_flags(host_flags), .conflict(conflict)
    );

    function automatic logic [7:0] b_comb(input logic [7:0] m, input logic [7:0] p);
        if (!(m inside {0, 1, 4, 5, 6}) || !(p inside {0, 1, 4, 5, 6, 7})) return 8'd2;
        case (m)
            8'd0: return (p == 1) ? 8'd1 : 8'd0;
            8'd1: return (p inside {1, 6, 7}) ? 8'd1 : 8'd0;
            8'd4: return (p == 6) ? 8'd4 : (p == 7) ? 8'd0 : p;
            8'd5: return (p == 6) ? 8'd5 : (p == 7) ? 8'd1 : p;
            default: return (p == 7) ? 8'd0 : p;
        endcase
    endfunction

    function automatic logic [8:0] b_rev(input logic [7:0] h, input logic [7:0] e);
        logic [8:0] r;
        r = {1'b1, 8'd0};
        foreach (r[i]) begin end
        for (int c = 7; c >= 0; c--) begin
            if (r[8] && (c inside {0, 1, 4, 5, 6, 7}) && b_comb(h, 8'(c)) == e)
                r = {1'b0, 8'(c)};
        end
        return r;
    endfunction

    function automatic logic [2:0] b_slot(input logic [63:0] hp, input logic [7:0] t);
        for (int k = 0; k < 8; k++) if (hp[8*k +: 8] == t) return 3'(k);
        for (int k = 0; k < 8; k++) if (hp[8*k +: 8] == 8'd0) return 3'(k);
        return 3'd0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [2:0] idx, input logic [63:0] gp, input logic [7:0] rm,
                          input bit bv, input logic [7:0] bm, input logic [7:0] hm,
                          input bit ld, input logic [63:0] newhp, input string req);
        logic [7:0]  e;
        logic [8:0]  rv;
        logic [2:0]  s;
        logic [12:0] exp, act;
        @(negedge clk);
        {pte_pat, pte_pcd, pte_pwt} = idx;
        guest_pat = gp; range_mtrr = rm; bypass_valid = bv; bypass_mtrr = bm;
        host_mtrr = hm; req_valid = 1'b1; hpat_load = ld; hpat_in = newhp;
        e  = b_comb(bv ? bm : rm, gp[8*idx +: 8]);
        rv = b_rev(hm, e);
        s  = b_slot(model_hpat, rv[7:0]);
        if (ld) model_hpat = newhp;
        exp = {1'b1, e, s, rv[8]};
        @(negedge clk);
        req_valid = 1'b0; hpat_load = 1'b0;
        act = {rsp_valid, eff_type, host_flags, conflict};
        check(act == exp, req, 64'(act), 64'(exp));
    endtask

    function automatic logic [7:0] rnd_type();
        logic [7:0] v [6] = '{0, 1, 4, 5, 6, 7};
        if ($urandom % 10 == 0) return 8'($urandom % 9);
        return v[$urandom % 6];
    endfunction

    function automatic logic [63:0] rnd_pat();
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = rnd_type();
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [12:0] held;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({rsp_valid, eff_type, host_flags, conflict} == 13'd0, "R1 reset outputs",
              64'({rsp_valid, eff_type, host_flags, conflict}), 64'd0);
        // R1 default host table: WB lands in slot 0, UC- in slot 2
        do_req(3'd0, 64'h0606060606060606, 8'd6, 0, 8'd0, 8'd6, 0, 0, "R1 default table WB");
        check(host_flags == 3'd0, "R1 slot0 WB", 64'(host_flags), 64'd0);
        do_req(3'd0, 64'h0, 8'd6, 0, 8'd0, 8'd4, 0, 0, "R1 default table UC to WT host");
        // R2 index bits: idx 5 = PAT|PWT
        do_req(3'd5, 64'h0000_0400_0000_0000 | 64'h0000_0000_0000_0606, 8'd6, 0, 8'd0, 8'd6, 0, 0, "R2 index select");
        check(eff_type == 8'd4, "R2 byte5 WT", 64'(eff_type), 64'd4);
        // R3 UC range with WC table gives WC; host table has no WC -> UC slot 3 (R7)
        do_req(3'd0, 64'h01, 8'd0, 0, 8'd0, 8'd6, 0, 0, "R3 UC+WC");
        check(host_flags == 3'd3, "R7 UC fallback slot", 64'(host_flags), 64'd3);
        do_req(3'd0, 64'h06, 8'd1, 0, 8'd0, 8'd6, 0, 0, "R3 WC range WB table");
        do_req(3'd0, 64'h05, 8'd1, 0, 8'd0, 8'd6, 0, 0, "R3 WC range WP table");
        // R4 rows and reserved codes
        do_req(3'd0, 64'h07, 8'd5, 0, 8'd0, 8'd6, 0, 0, "R4 WP range UC-");
        do_req(3'd0, 64'h06, 8'd4, 0, 8'd0, 8'd6, 0, 0, "R4 WT range WB");
        do_req(3'd0, 64'h07, 8'd6, 0, 8'd0, 8'd6, 0, 0, "R4 WB range UC-");
        do_req(3'd0, 64'h06, 8'd3, 0, 8'd0, 8'd6, 0, 0, "R4 reserved range");
        check(eff_type == 8'd2 && conflict, "R4 reserved gives 2", 64'({eff_type, conflict}), 64'h5);
        do_req(3'd0, 64'h02, 8'd6, 0, 8'd0, 8'd6, 0, 0, "R4 reserved table");
        // R5 bypass replaces / ignored
        do_req(3'd0, 64'h06, 8'd0, 1, 8'd6, 8'd6, 0, 0, "R5 bypass on");
        check(eff_type == 8'd6, "R5 bypass WB", 64'(eff_type), 64'd6);
        do_req(3'd0, 64'h06, 8'd0, 0, 8'd6, 8'd6, 0, 0, "R5 bypass off");
        check(eff_type == 8'd0, "R5 bypass ignored", 64'(eff_type), 64'd0);
        // R6 conflict: host UC, effective WB
        do_req(3'd0, 64'h06, 8'd6, 0, 8'd0, 8'd0, 0, 0, "R6 conflict");
        check(conflict && host_flags == 3'd3, "R6 conflict UC slot", 64'({host_flags, conflict}), 64'h7);
        // R6 highest code: host WB, eff UC -> UC- slot 2
        do_req(3'd0, 64'h00, 8'd6, 0, 8'd0, 8'd6, 0, 0, "R6 highest code");
        check(host_flags == 3'd2, "R6 UC- chosen", 64'(host_flags), 64'd2);
        // R9 load during request uses the old table, then the new table applies
        do_req(3'd0, 64'h01, 8'd6, 0, 8'd0, 8'd6, 1, 64'h0101_0001_0000_0606, "R9 load same cycle");
        do_req(3'd0, 64'h01, 8'd6, 0, 8'd0, 8'd6, 0, 0, "R9 new table");
        check(host_flags == 3'd4, "R7 lowest duplicate", 64'(host_flags), 64'd4);
        // R7 no match and no UC -> slot 0
        do_req(3'd0, 64'h00, 8'd6, 0, 8'd0, 8'd6, 1, 64'h0606_0606_0606_0606, "R7 load");
        do_req(3'd0, 64'h05, 8'd6, 0, 8'd0, 8'd6, 0, 0, "R7 slot0 fallback");
        // R8 idle cycle: no response, outputs held
        held = {1'b0, eff_type, host_flags, conflict};
        @(negedge clk);
        guest_pat = 64'h0; range_mtrr = 8'd0; host_mtrr = 8'd0;
        @(negedge clk);
        check({rsp_valid, eff_type, host_flags, conflict} == held, "R8 hold",
              64'({rsp_valid, eff_type, host_flags, conflict}), 64'(held));
        // Random mix
        for (int n = 0; n < 400; n++) begin
            bit ld;
            ld = ($urandom % 8 == 0);
            do_req(3'($urandom), rnd_pat(), rnd_type(), 1'($urandom), rnd_type(), rnd_type(),
                   ld, rnd_pat(), "R6 R7 random");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule